// File: doc/BRIEF.md
# Four-Lane SD Data CRC16 Generator

This block computes the CRC16 check words that follow a data block on a 4-bit-wide SD data bus. It holds one independent CRC16 register for each data line. Bytes arrive through a valid/ready interface. Each byte is split into two nibbles, and each nibble updates every lane by one bit. When the block is complete, the four lane CRCs are emitted as 16 nibbles, packed into 8 bytes on a valid/ready output.

A controller pulses `start_i` with the block length on `len_i`, which is normally 512 bytes per sector. It then feeds the bytes. Once the last byte is taken, `done_o` pulses and the 8 CRC bytes become available. After the eighth byte is taken the block returns to idle.

Top module: `sd_crc16x4`

## Requirements
- R1: After reset, `in_ready_o`, `out_valid_o` and `done_o` are low.
- R2: A `start_i` pulse while idle clears all four lanes to zero and loads `len_i` as the byte count. If the length is nonzero, `in_ready_o` is high from the next cycle.
- R3: Each lane is a 16-bit CRC with polynomial 0x1021. Per data bit, the lane shifts left, XORs 0x1021 if the bit shifted out was 1, and XORs 0x1021 again if the data bit is 1.
- R4: The high nibble of a byte is applied first: lane 0 takes bit 7, lane 1 bit 6, lane 2 bit 5 and lane 3 bit 4.
- R5: The low nibble is applied second: lane 0 takes bit 3, lane 1 bit 2, lane 2 bit 1 and lane 3 bit 0.
- R6: The output is 16 nibble steps. Each step places the lane MSBs in a nibble, with lane 0 in bit 3 and lane 3 in bit 0, and then shifts every lane left by one. Two steps form one output byte, with the earlier nibble in bits 7:4, so a block yields 8 bytes.
- R7: In the cycle after the last byte is accepted:
  - `in_ready_o` is low.
  - `out_valid_o` is high.
  - `done_o` is high for exactly that one cycle.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` and `out_valid_o` hold. After the 8th accepted output byte, `out_valid_o` drops and the block is idle.
- R9: `start_i` outside idle has no effect. `in_valid_i` while `in_ready_o` is low does not update any lane.
- R10: A start with length 0 skips the data phase and produces 8 zero bytes, with `done_o` pulsing as in R7.
- R11: Cycles with `in_valid_i` low during the data phase leave the lanes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a block (idle only) |
| len_i | input | LEN_W | Block length in bytes |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Block accepts a byte |
| done_o | output | 1 | One-cycle pulse after the last byte |
| out_valid_o | output | 1 | CRC byte valid |
| out_data_o | output | 8 | CRC byte, earlier nibble high |
| out_ready_i | input | 1 | Consumer takes CRC byte |

## Verification
The bench uses the default `LEN_W` of 10, so a full 512-byte sector fits in the length field. The same build also reaches single-byte blocks and a zero-length block. Single-byte patterns with only one nibble set isolate the bit-to-lane mapping. Gapped input, output backpressure, and start pulses injected during the data and output phases reach the stall and ignore paths.

// File: rtl/sd_crc16x4_pkg.sv
package sd_crc16x4_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned CRC_W = 16;
  localparam logic [CRC_W-1:0] POLY = 16'h1021;
  localparam int unsigned OUT_BYTES = (LANES * CRC_W) / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_OUT} st_e;

  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic d,
                                                logic [CRC_W-1:0] poly);
    return {c[CRC_W-2:0], 1'b0} ^ ((c[CRC_W-1] ^ d) ? poly : '0);
  endfunction
endpackage

// File: rtl/crc16_lane.sv
module crc16_lane
  import sd_crc16x4_pkg::*;
#(
  parameter logic [CRC_W-1:0] LANE_POLY = POLY
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [1:0]       bits_i,   // bits_i[1] applied first
  input  logic             shift_i,  // drain two bits
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr_i)        crc_d = '0;
    else if (upd_i)   crc_d = crc_step(crc_step(crc_q, bits_i[1], LANE_POLY), bits_i[0], LANE_POLY);
    else if (shift_i) crc_d = {crc_q[CRC_W-3:0], 2'b00};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '0;
    else         crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  p_clear_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_q == '0);
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !upd_i && !shift_i) |=> $stable(crc_q));
endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
  import sd_crc16x4_pkg::*;
#(
  parameter int unsigned LEN_W = 10,
  parameter int unsigned NBYTES = OUT_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             in_valid_i,
  input  logic             out_ready_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             done_o,
  output logic             clr_o,
  output logic             upd_o,
  output logic             shift_o
);
  localparam int unsigned OC_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [OC_W-1:0] OC_LAST = OC_W'(NBYTES - 1);

  st_e              st_q, st_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [OC_W-1:0]  oc_q, oc_d;
  logic             done_d, done_q;

  assign in_ready_o  = (st_q == ST_DATA);
  assign out_valid_o = (st_q == ST_OUT);
  assign clr_o       = (st_q == ST_IDLE) && start_i;
  assign upd_o       = in_ready_o && in_valid_i;
  assign shift_o     = out_valid_o && out_ready_i;
  assign done_o      = done_q;

  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    oc_d   = oc_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        rem_d = len_i;
        oc_d  = '0;
        if (len_i == '0) begin
          st_d   = ST_OUT;
          done_d = 1'b1;
        end else begin
          st_d = ST_DATA;
        end
      end
      ST_DATA: if (upd_o) begin
        rem_d = rem_q - 1'b1;
        if (rem_q == LEN_W'(1)) begin
          st_d   = ST_OUT;
          done_d = 1'b1;
        end
      end
      ST_OUT: if (shift_o) begin
        oc_d = oc_q + 1'b1;
        if (oc_q == OC_LAST) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      oc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      oc_q   <= oc_d;
      done_q <= done_d;
    end
  end

  p_phase_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));
  p_done_with_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> out_valid_o && !in_ready_o);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o);
  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && start_i && !in_valid_i) |=> in_ready_o);
endmodule

// File: rtl/sd_crc16x4.sv
module sd_crc16x4
  import sd_crc16x4_pkg::*;
#(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             done_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  input  logic             out_ready_i
);
  logic clr, upd, shift;
  logic [LANES-1:0] nib_hi, nib_lo;

  crc_seq_ctrl #(.LEN_W(LEN_W), .NBYTES(OUT_BYTES)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .len_i, .in_valid_i, .out_ready_i,
    .in_ready_o, .out_valid_o, .done_o,
    .clr_o(clr), .upd_o(upd), .shift_o(shift)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [CRC_W-1:0] crc;
    crc16_lane #(.LANE_POLY(POLY)) u_lane (
      .clk_i, .rst_ni,
      .clr_i(clr), .upd_i(upd),
      .bits_i({in_data_i[2*LANES-1-k], in_data_i[LANES-1-k]}),
      .shift_i(shift),
      .crc_o(crc)
    );
    assign nib_hi[LANES-1-k] = crc[CRC_W-1];
    assign nib_lo[LANES-1-k] = crc[CRC_W-2];
  end

  assign out_data_o = {nib_hi, nib_lo};

  p_data_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> $stable(out_data_o));
endmodule

// File: tb/sd_crc16x4_tb_top.sv
module sd_crc16x4_tb_top;
  localparam int LEN_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic out_ready = 1'b0;
  logic in_ready, done, out_valid;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  sd_crc16x4 #(.LEN_W(LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .done_o(done), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_ready_i(out_ready)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_tag = "R3";
  int done_seen = 0;

  // behavioural reference: 0 idle, 1 data, 2 output
  int phase = 0;
  int rem = 0;
  int oidx = 0;
  bit m_done = 0;
  logic [15:0] ml[4];
  logic [7:0] mb[8];

  function automatic logic [15:0] ser_bit(logic [15:0] c, bit d);
    bit fb = c[15] ^ d;
    c = c << 1;
    if (fb) c = c ^ 16'h1021;
    return c;
  endfunction

  task automatic build_out();
    logic [15:0] t[4];
    logic [3:0] nib;
    for (int k = 0; k < 4; k++) t[k] = ml[k];
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 4; k++) begin
        nib[3-k] = t[k][15];
        t[k] = t[k] << 1;
      end
      if (s % 2 == 0) mb[s/2][7:4] = nib;
      else            mb[s/2][3:0] = nib;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; m_done = 0; rem = 0; oidx = 0;
      for (int k = 0; k < 4; k++) ml[k] = '0;
    end else begin
      m_done = 0;
      case (phase)
        0: if (start) begin
          for (int k = 0; k < 4; k++) ml[k] = '0;
          rem = int'(len); oidx = 0;
          if (rem == 0) begin phase = 2; m_done = 1; build_out(); end
          else phase = 1;
        end
        1: if (in_valid) begin
          for (int k = 0; k < 4; k++) ml[k] = ser_bit(ml[k], in_data[7-k]);
          for (int k = 0; k < 4; k++) ml[k] = ser_bit(ml[k], in_data[3-k]);
          rem--;
          if (rem == 0) begin phase = 2; m_done = 1; build_out(); end
        end
        default: if (out_ready) begin
          oidx++;
          if (oidx == 8) phase = 0;
        end
      endcase
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(in_ready == (phase == 1), "R2", int'(in_ready), int'(phase == 1));
      chk(out_valid == (phase == 2), "R8", int'(out_valid), int'(phase == 2));
      chk(done == m_done, "R7", int'(done), int'(m_done));
      if (done) done_seen++;
      if (out_valid && phase == 2)
        chk(out_data == mb[oidx], cur_tag, int'(out_data), int'(mb[oidx]));
    end
  end

  function automatic logic [7:0] pat(int sel, int i);
    case (sel)
      0: return 8'hF0;
      1: return 8'h0F;
      2: return 8'h80;
      3: return 8'h01;
      default: return 8'((i * 37 + 5) ^ (i >> 3));
    endcase
  endfunction

  task automatic run_block(int n, int sel, bit gaps, bit bp, bit inject);
    int idx = 0;
    int got = 0;
    int c = 0;
    bit fire;
    done_seen = 0;
    @(negedge clk);
    start = 1'b1; len = LEN_W'(n);
    @(negedge clk);
    start = 1'b0;
    if (n > 0) chk(in_ready == 1'b1, "R2", int'(in_ready), 1);
    while (idx < n) begin
      in_valid = gaps ? (c % 3 != 1) : 1'b1;
      in_data = pat(sel, idx);
      start = inject && (c == 2);
      fire = in_valid && in_ready;
      c++;
      @(negedge clk);
      if (fire) idx++;
    end
    in_valid = 1'b0; start = 1'b0;
    c = 0;
    while (got < 8) begin
      out_ready = bp ? (c % 3 == 2) : 1'b1;
      start = inject && (c == 1);
      in_valid = inject && (c == 1);
      in_data = 8'hFF;
      fire = out_ready && out_valid;
      c++;
      @(negedge clk);
      if (fire) got++;
      if (c > 200) break;
    end
    out_ready = 1'b0; start = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk(done_seen == 1, "R7", done_seen, 1);
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R8", int'(out_valid), 0);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) ml[k] = '0;
    for (int b = 0; b < 8; b++) mb[b] = '0;
    repeat (3) @(negedge clk);
    chk(in_ready == 0, "R1", int'(in_ready), 0);
    chk(out_valid == 0, "R1", int'(out_valid), 0);
    chk(done == 0, "R1", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cur_tag = "R4"; run_block(1, 0, 0, 0, 0);
    cur_tag = "R4"; run_block(1, 2, 0, 0, 0);
    cur_tag = "R5"; run_block(1, 1, 0, 0, 0);
    cur_tag = "R5"; run_block(1, 3, 0, 0, 0);
    cur_tag = "R3"; run_block(512, 4, 0, 0, 0);
    cur_tag = "R10"; run_block(0, 4, 0, 0, 0);
    for (int b = 0; b < 8; b++) chk(mb[b] == 8'h00, "R10", int'(mb[b]), 0);
    cur_tag = "R11"; run_block(40, 4, 1, 0, 0);
    cur_tag = "R8"; run_block(7, 4, 0, 1, 0);
    cur_tag = "R9"; run_block(20, 4, 1, 1, 1);
    cur_tag = "R6"; run_block(3, 4, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule